// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol core of a byte-addressed serial memory that sits on a two-wire bus as a slave. A line front end turns the raw clock and data wires into single-cycle events: a start, a stop, a clock rise carrying the sampled data value, and a clock fall. The controller tracks the bit position within each 9-slot byte frame. It decodes a select byte and collects a two-byte address. It stores write data into a page buffer and fetches read data from an array port. It answers on the bus only through an open-drain pull-down request.

Writes go into the buffer through a byte-wide port. The commit strobe tells the write engine to program the buffered bytes. While that engine reports busy, the controller stays silent, so a master can poll with select bytes until one is acknowledged. A write-lock input suppresses data storage and commit but leaves the addressing bytes acknowledged. Reads ignore this input.

Top module: `i2cm_slave`

## Requirements
- R1: After reset the pull-down request, the commit strobe and the buffer write strobe are all low.
- R2: A select byte is acknowledged (pull-down during the 9th slot) only when its upper nibble is 1010 and its bits 3..1 equal `chip_sel`. Bit 0 picks the direction: 1 means read and 0 means write. On a mismatch the controller never pulls down again until the next start.
- R3: After a write select, two address bytes follow, high byte first. Each of them is acknowledged. Only the low `AW` bits of the 16-bit value select a location.
- R4: Without write lock, each data byte is acknowledged and goes to the buffer at the current address. After each byte only the low `PW` address bits advance, wrapping inside the page.
- R5: If `wr_lock` is high in any cycle from the start through the second address byte, the select and address bytes are still acknowledged. Every data byte then gets NoAck, and nothing is stored or committed.
- R6: A commit is issued only for a stop that follows the clock rise right after an acknowledged data byte's ACK slot. A stop at any other position commits nothing.
- R7: While `busy` is high, no select byte is acknowledged.
- R8: A random read loads the address through the write sequence. A repeated start and a read select follow, and the controller then returns the byte at that address.
- R9: Read bits go out MSB first, changing after clock falls, and the line is released during the ACK slot. After each byte the address increments. A master ACK continues with the next byte, and a NoAck returns the controller to standby.
- R10: A sequential read past the last location continues from address 0.
- R11: Reads behave the same whatever the level of `wr_lock`.
- R12: A start seen in the middle of a byte abandons the transfer, discards the partial byte and restarts at the select byte.
- R13: A current-address read returns the byte at the internal counter. After a committed page write, the counter points one past the last byte written, with wrap inside the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| start_evt | input | 1 | Start or repeated start detected |
| stop_evt | input | 1 | Stop detected |
| rise_evt | input | 1 | Bus clock rising edge |
| rise_sda | input | 1 | Data line value sampled at that rise |
| fall_evt | input | 1 | Bus clock falling edge |
| chip_sel | input | 3 | Strapped select address |
| wr_lock | input | 1 | Write protect |
| busy | input | 1 | Write engine programming |
| rd_addr | output | AW | Array read address |
| rd_data | input | 8 | Array read data |
| wb_we | output | 1 | Buffer write strobe |
| wb_addr | output | AW | Buffer write address |
| wb_data | output | 8 | Buffer write data |
| wb_clear | output | 1 | New write sequence addressed; discard buffer |
| wr_commit | output | 1 | Start programming buffered bytes |
| sda_low | output | 1 | Request to pull the data line low |

## Verification
The bench builds the controller with `AW` = 6 and `PW` = 3, which gives a 64-byte array split into 8-byte pages. With this size, a page write wraps inside its page after a few bytes, and a sequential read crosses the top of the array within three bytes. All 256 select byte values are swept against one strap setting, and every write select is swept across all eight straps. The bench also models the buffer, the array and a busy write engine arithmetically, so commit placement, lock handling and ACK polling are checked against predicted array contents.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE, S_SEL, S_AHI, S_ALO, S_WDAT, S_RDAT
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [3:0] bcnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] ahi;
        logic       ack;
        logic       lock;
        logic       arm;
        logic       sda;
        logic       commit;
    } ctl_t;
endpackage

// File: rtl/i2cm_sel_match.sv
module i2cm_sel_match (
    input  logic [6:0] sel_bits,
    input  logic [2:0] chip_sel,
    input  logic       busy,
    output logic       hit
);
    import i2cm_pkg::*;
    always_comb begin
        hit = (sel_bits[6:3] == DEV_TYPE) && (sel_bits[2:0] == chip_sel) && !busy;
    end
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)
            addr_d = load_val;
        else if (inc_page)
            addr_d = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
        else if (inc_full)
            addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    a_r4_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])));
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          rise_evt,
    input  logic          rise_sda,
    input  logic          fall_evt,
    input  logic [2:0]    chip_sel,
    input  logic          wr_lock,
    input  logic          busy,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wb_we,
    output logic [AW-1:0] wb_addr,
    output logic [7:0]    wb_data,
    output logic          wb_clear,
    output logic          wr_commit,
    output logic          sda_low
);
    import i2cm_pkg::*;

    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_SLOT = 4'd8;

    ctl_t q, n;
    logic          sel_hit;
    logic [7:0]    full_byte;
    logic [15:0]   full_addr;
    logic [AW-1:0] cur_addr;
    logic          ld_addr, inc_full;

    assign full_byte = {q.sh[6:0], rise_sda};
    assign full_addr = {q.ahi, q.sh};

    i2cm_sel_match u_sel (
        .sel_bits (full_byte[7:1]),
        .chip_sel (chip_sel),
        .busy     (busy),
        .hit      (sel_hit)
    );

    assign ld_addr  = rise_evt && (q.bcnt == ACK_SLOT) && (q.ph == S_ALO) && !start_evt && !stop_evt;
    assign inc_full = rise_evt && (q.bcnt == ACK_SLOT) && (q.ph == S_RDAT) && !start_evt && !stop_evt;
    assign wb_we    = rise_evt && (q.bcnt == LAST_BIT) && (q.ph == S_WDAT) && !q.lock
                      && !start_evt && !stop_evt;
    assign wb_clear = ld_addr;

    i2cm_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val (full_addr[AW-1:0]),
        .inc_page (wb_we),
        .inc_full (inc_full),
        .addr_o   (cur_addr)
    );

    assign rd_addr   = cur_addr;
    assign wb_addr   = cur_addr;
    assign wb_data   = full_byte;
    assign wr_commit = q.commit;
    assign sda_low   = q.sda;

    always_comb begin
        n        = q;
        n.commit = 1'b0;
        if (start_evt) begin
            n.ph   = S_SEL;
            n.bcnt = '0;
            n.sda  = 1'b0;
            n.arm  = 1'b0;
            n.lock = wr_lock;
        end else if (stop_evt) begin
            n.commit = q.arm;
            n.ph     = S_IDLE;
            n.bcnt   = '0;
            n.sda    = 1'b0;
            n.arm    = 1'b0;
        end else begin
            if (q.ph == S_SEL || q.ph == S_AHI || q.ph == S_ALO)
                n.lock = q.lock | wr_lock;
            if (rise_evt && q.ph != S_IDLE) begin
                if (q.bcnt != ACK_SLOT) begin
                    n.sh   = full_byte;
                    n.bcnt = q.bcnt + 4'd1;
                    if (q.bcnt != 4'd0) n.arm = 1'b0;
                    if (q.bcnt == LAST_BIT) begin
                        unique case (q.ph)
                            S_SEL:         n.ack = sel_hit;
                            S_AHI, S_ALO:  n.ack = 1'b1;
                            S_WDAT:        n.ack = !q.lock;
                            default:       n.ack = 1'b0;
                        endcase
                    end
                end else begin
                    n.bcnt = '0;
                    n.arm  = 1'b0;
                    unique case (q.ph)
                        S_SEL:   n.ph = !q.sda ? S_IDLE : (q.sh[0] ? S_RDAT : S_AHI);
                        S_AHI: begin
                            n.ahi = q.sh;
                            n.ph  = S_ALO;
                        end
                        S_ALO:   n.ph  = S_WDAT;
                        S_WDAT:  n.arm = q.ack;
                        S_RDAT:  if (rise_sda) n.ph = S_IDLE;
                        default: n.ph = S_IDLE;
                    endcase
                end
            end
            if (fall_evt) begin
                if (q.bcnt != 4'd0) n.arm = 1'b0;
                if (q.ph == S_IDLE)
                    n.sda = 1'b0;
                else if (q.bcnt == ACK_SLOT)
                    n.sda = (q.ph != S_RDAT) && q.ack && !(q.ph == S_SEL && busy);
                else if (q.ph == S_RDAT) begin
                    if (q.bcnt == 4'd0) begin
                        n.tx  = rd_data;
                        n.sda = !rd_data[7];
                    end else begin
                        n.sda = !q.tx[3'd7 - q.bcnt[2:0]];
                    end
                end else
                    n.sda = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: S_IDLE, default: '0};
        else        q <= n;
    end

    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == S_IDLE) |-> !sda_low);
    a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == S_SEL && busy && fall_evt && !start_evt && !stop_evt) |=> !sda_low);
    a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_evt));
    a_r12_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (q.ph == S_SEL && q.bcnt == 4'd0 && !sda_low));
    a_r9_release_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == S_RDAT && q.bcnt == ACK_SLOT && fall_evt && !start_evt && !stop_evt) |=> !sda_low);
endmodule

// File: tb/i2cm_slave_tb.sv
module i2cm_slave_tb;
    localparam int AW = 6;
    localparam int PW = 3;
    localparam int DEPTH = 1 << AW;
    localparam int PMASK = (1 << PW) - 1;

    logic clk = 0, rst_n = 0;
    logic start_evt = 0, stop_evt = 0, rise_evt = 0, rise_sda = 0, fall_evt = 0;
    logic [2:0] chip_sel = 3'b101;
    logic wr_lock = 0, busy;
    logic [AW-1:0] rd_addr, wb_addr;
    logic [7:0] rd_data, wb_data;
    logic wb_we, wb_clear, wr_commit, sda_low;

    always #5 clk = ~clk;

    i2cm_slave #(.AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .rise_evt(rise_evt), .rise_sda(rise_sda), .fall_evt(fall_evt),
        .chip_sel(chip_sel), .wr_lock(wr_lock), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data), .wb_we(wb_we), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_clear(wb_clear), .wr_commit(wr_commit), .sda_low(sda_low)
    );

    logic [7:0] mem [DEPTH];
    logic [7:0] pend [DEPTH];
    logic [DEPTH-1:0] pv;
    int busy_cnt, commits, we_cnt;
    logic [7:0] refm [DEPTH];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    assign rd_data = mem[rd_addr];
    assign busy = busy_cnt != 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 3);
            pv <= '0; busy_cnt <= 0; commits <= 0; we_cnt <= 0;
        end else begin
            if (wb_clear) pv <= '0;
            if (wb_we) begin
                pend[wb_addr] <= wb_data; pv[wb_addr] <= 1'b1; we_cnt <= we_cnt + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < DEPTH; i++) if (pv[i]) mem[i] <= pend[i];
                busy_cnt <= 200; commits <= commits + 1;
            end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int k); repeat (k) @(negedge clk); endtask
    task automatic ev_rise(input logic v);
        rise_sda = v; rise_evt = 1; tick(1); rise_evt = 0; tick(2);
    endtask
    task automatic ev_fall(); fall_evt = 1; tick(1); fall_evt = 0; tick(2); endtask
    task automatic ev_start(); start_evt = 1; tick(1); start_evt = 0; tick(2); endtask
    task automatic ev_stop(); stop_evt = 1; tick(1); stop_evt = 0; tick(2); endtask

    task automatic begin_x(); ev_start(); ev_fall(); endtask
    task automatic restart_x(); ev_rise(1'b1); ev_start(); ev_fall(); endtask
    task automatic end_x(); ev_rise(1'b0); ev_stop(); endtask

    task automatic send_bit(input logic b); ev_rise(b & ~sda_low); ev_fall(); endtask

    task automatic send_byte(input logic [7:0] b, output bit ak);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ak = sda_low;
        ev_rise(~sda_low); ev_fall();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            b[i] = ~sda_low; ev_rise(b[i]); ev_fall();
        end
        chk("R9 release in ack slot", sda_low, 0);
        ev_rise(mack ? 1'b0 : 1'b1); ev_fall();
    endtask

    function automatic logic [7:0] selw(); return {4'b1010, chip_sel, 1'b0}; endfunction
    function automatic logic [7:0] selr(); return {4'b1010, chip_sel, 1'b1}; endfunction
    function automatic int pg(input int a, input int k);
        return (a & ~PMASK) | ((a + k) & PMASK);
    endfunction

    task automatic wait_idle(); while (busy) tick(1); endtask

    task automatic do_write(input int a, input int cnt, input int base);
        bit ak; int c0;
        begin_x();
        send_byte(selw(), ak); chk("R2 write select ack", ak, 1);
        send_byte(8'hC0, ak);  chk("R3 high address ack", ak, 1);
        send_byte(8'(a), ak);  chk("R3 low address ack", ak, 1);
        for (int k = 0; k < cnt; k++) begin
            send_byte(8'(base + k), ak); chk("R4 data ack", ak, 1);
            refm[pg(a, k)] = 8'(base + k);
        end
        c0 = commits;
        end_x();
        chk("R6 commit after data ack", commits, c0 + 1);
        wait_idle();
    endtask

    task automatic rand_read(input int a, input int cnt, input string req);
        bit ak; logic [7:0] b;
        begin_x();
        send_byte(selw(), ak); send_byte(8'h00, ak); send_byte(8'(a), ak);
        restart_x();
        send_byte(selr(), ak); chk("R8 read select ack", ak, 1);
        for (int k = 0; k < cnt; k++) begin
            recv_byte(b, k != cnt - 1);
            chk(req, b, refm[(a + k) % DEPTH]);
        end
        end_x();
    endtask

    task automatic cur_read(input int a, input string req);
        bit ak; logic [7:0] b;
        begin_x();
        send_byte(selr(), ak); chk("R13 current read select ack", ak, 1);
        recv_byte(b, 0);
        chk(req, b, refm[a]);
        end_x();
    endtask

    initial begin
        bit ak; int c0, w0, tries; logic [7:0] code, b;
        for (int i = 0; i < DEPTH; i++) refm[i] = 8'(i * 7 + 3);
        tick(3);
        chk("R1 sda released", sda_low, 0);
        chk("R1 no commit", wr_commit, 0);
        chk("R1 no buffer write", wb_we, 0);
        rst_n = 1; tick(2);
        chk("R1 sda after reset", sda_low, 0);

        // R2: full select byte sweep
        c0 = commits;
        for (int v = 0; v < 256; v++) begin
            code = 8'(v);
            begin_x();
            send_byte(code, ak);
            chk("R2 select decode", ak, (code[7:1] == {4'b1010, chip_sel}) ? 1 : 0);
            if (ak && code[0]) recv_byte(b, 0);
            else if (!ak) begin
                send_byte(8'h00, ak); chk("R2 silent after mismatch", ak, 0);
            end
            end_x();
        end
        for (int cs = 0; cs < 8; cs++) begin
            chip_sel = 3'(cs);
            for (int e = 0; e < 8; e++) begin
                begin_x(); send_byte({4'b1010, 3'(e), 1'b0}, ak);
                chk("R2 strap compare", ak, (e == cs) ? 1 : 0);
                end_x();
            end
        end
        chip_sel = 3'b101;
        chk("R6 no commit in select sweep", commits, c0);

        // R4/R6/R8 byte write then random read
        do_write(6'h13, 1, 8'h5A);
        rand_read(6'h13, 1, "R8 random read of written byte");

        // R7 polling
        begin_x(); send_byte(selw(), ak); send_byte(8'h00, ak); send_byte(8'h05, ak);
        send_byte(8'h77, ak); refm[5] = 8'h77; end_x();
        begin_x(); send_byte(selw(), ak); chk("R7 no ack while busy", ak, 0); end_x();
        tries = 0;
        do begin
            begin_x(); send_byte(selw(), ak); end_x(); tries++;
        end while (!ak && tries < 20);
        chk("R7 ack after busy ends", ak, 1);
        wait_idle();
        rand_read(5, 1, "R7 polled write landed");

        // R4 page wrap, R13 counter after write
        do_write(6'h1D, 5, 8'hA0);
        cur_read(pg(6'h1D, 5), "R13 counter past last written");
        rand_read(6'h18, 8, "R4 page wrap contents");

        // R10 wrap, R9 increment after byte
        rand_read(DEPTH - 2, 3, "R10 sequential wrap");
        cur_read(1, "R9 counter after sequential read");

        // R5 write lock pulse during high address byte
        c0 = commits; w0 = we_cnt;
        begin_x();
        send_byte(selw(), ak); chk("R5 select acked under lock", ak, 1);
        wr_lock = 1; send_byte(8'h00, ak); wr_lock = 0;
        chk("R5 high address acked under lock", ak, 1);
        send_byte(8'h22, ak); chk("R5 low address acked under lock", ak, 1);
        send_byte(8'h11, ak); chk("R5 data nack", ak, 0);
        send_byte(8'h12, ak); chk("R5 second data nack", ak, 0);
        end_x();
        chk("R5 no commit", commits, c0);
        chk("R5 no buffer write", we_cnt, w0);
        rand_read(6'h22, 2, "R5 memory unchanged");

        // R11 reads with lock high
        wr_lock = 1;
        rand_read(6'h13, 1, "R11 read ignores lock");
        cur_read(6'h14, "R11 current read ignores lock");
        wr_lock = 0;

        // R6 stop at wrong positions
        c0 = commits;
        begin_x(); send_byte(selw(), ak); send_byte(8'h00, ak); send_byte(8'h30, ak);
        send_byte(8'hEE, ak); send_bit(1'b0); end_x();
        chk("R6 no commit when stop late", commits, c0);
        begin_x(); send_byte(selw(), ak); send_byte(8'h00, ak); send_byte(8'h31, ak); end_x();
        chk("R6 no commit after address only", commits, c0);
        rand_read(6'h30, 2, "R6 memory unchanged");

        // R12 start mid-byte
        c0 = commits;
        begin_x(); send_byte(selw(), ak); send_byte(8'h00, ak); send_byte(8'h21, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        restart_x();
        send_byte(selr(), ak); chk("R12 select after abort", ak, 1);
        recv_byte(b, 0); chk("R12 read after abort", b, refm[6'h21]);
        end_x();
        chk("R12 no commit", commits, c0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule